// File: doc/BRIEF.md
# Multi-channel PWM waveform core

This block produces four pulse-width-modulated outputs from a single shared counter. A power-of-two prescaler divides the system clock into counter ticks. The counter either climbs from zero to a top value and restarts, which gives edge-aligned pulses, or climbs to the top and falls back, which gives center-aligned pulses. The choice is made at run time. Each channel compares the counter with a 15-bit value of its own. The sixteenth bit of that word sets the output polarity.

Compare values reach the block as 16-bit words over a valid/ready handshake from an upstream sequencer. A word decoder spreads each group of words across the channels in one of four load modes. In the fourth mode the last word of each group sets the counter top. Everything a group carries is held in a pending buffer and only becomes active at the start of the next PWM period. A one-cycle period-end strobe tells the sequencer when that hand-over has happened. Any channel can be disconnected, which holds it low.

Top module: `pwm_core`

## Requirements
- R1: The counter advances once every 2^div_sel clock cycles (div_sel 0 to 7), so every period length and every high time scales by that factor.
- R2: With center_mode = 0 the counter runs 0, 1, … T and then restarts, giving a period of T+1 ticks. A channel with compare value C is high for min(C, T+1) ticks, starting at the beginning of the period.
- R3: With center_mode = 1 and T ≥ 1 the counter runs 0 … T and then T-1 … 1, giving a period of 2T ticks. The high time is 0 ticks for C = 0, 2C-1 ticks for 1 ≤ C ≤ T, and 2T ticks for C > T.
- R4: The compare value is bits [14:0] of a word. When bit 15 is 1, the output is inverted, so the high time becomes the period minus the R2/R3 figure.
- R5: With load_mode = 0 (common), every accepted word goes to all four channels, and one word forms a group.
- R6: With load_mode = 1 (paired), a group is two words. The first goes to channels 0 and 1, the second to channels 2 and 3.
- R7: With load_mode = 2 (separate), a group is four words, which go to channels 0, 1, 2 and 3 in that order.
- R8: With load_mode = 3 (waveform), words 1 to 3 of a group go to channels 0 to 2. Bits [14:0] of word 4 become the counter top, and top_cfg is ignored. Channel 3 stays low in this mode.
- R9: A channel whose chan_off bit is 1 stays low.
- R10: Compare values and the top value change only at a period boundary. period_end is high for exactly the first clock cycle of each new period, and the values loaded at that boundary are in force from that cycle on.
- R11: wd_ready falls after the last word of a group is accepted. It stays low until the next period boundary, or for one cycle while enable is low. A word offered while wd_ready is low is not taken.
- R12: A change of load_mode restarts the word position at the first word of a group.
- R13: While enable is low, all outputs and period_end are low, the counter is held at zero, and pending values are copied to the active set every cycle. Out of reset, all outputs are low and wd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the prescaler and counter; low holds everything idle |
| div_sel | input | 3 | Prescaler select: divide by 2^div_sel |
| center_mode | input | 1 | 0 = up-only (edge-aligned), 1 = up-and-down (center-aligned) |
| load_mode | input | 2 | 0 common, 1 paired, 2 separate, 3 waveform |
| top_cfg | input | 15 | Counter top in load modes 0 to 2 |
| chan_off | input | 4 | Per-channel disconnect; 1 holds the output low |
| wd_valid | input | 1 | Load word offered |
| wd_data | input | 16 | Load word: [14:0] value, [15] polarity |
| wd_ready | output | 1 | Decoder can accept a word |
| pwm_out | output | 4 | Channel outputs |
| period_end | output | 1 | One-cycle strobe in the first cycle of each new period |

## Verification
The bench measures whole periods between period_end strobes. Each period's length and each channel's high time are compared with values computed from the counting rules. Compare values above the top and a value of zero are covered in both counting modes. A counter that turns round one step late in center mode would give 2T+1 ticks and high times off by one. A mid-period word burst must leave the current period untouched and take effect in the next one; a design that loaded at once would show a mixed period. The bench also checks the handshake low after a full group, and a mode change after a stray word. Without the word position restart, that word would shift every channel by one.

// File: rtl/pwm_core_pkg.sv
package pwm_core_pkg;
    localparam int NCH = 4;

    typedef enum logic [1:0] {
        LD_COMMON   = 2'd0,
        LD_PAIRED   = 2'd1,
        LD_SEPARATE = 2'd2,
        LD_WAVE     = 2'd3
    } load_mode_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [PSW-1:0] sel,
    output logic           tick
);
    localparam int DW = (1 << PSW) - 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [DW-1:0] mask;

    always_comb begin
        s_d   = s_q;
        mask  = ~({DW{1'b1}} << sel);
        tick  = en & ((s_q.cnt & mask) == mask);
        s_d.cnt = en ? s_q.cnt + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW      = 15,
    parameter int TOP_RST = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          center,
    input  logic [CW-1:0] top_next,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] top_act,
    output logic          load,
    output logic          period_end
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
        logic [CW-1:0] top;
        logic          pend;
    } st_t;

    st_t  s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (!center) s_d.down = 1'b0;
        if (!en) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
        end else if (tick) begin
            if (!center) begin
                if (s_q.cnt >= s_q.top) begin
                    wrap    = 1'b1;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (!s_q.down) begin
                if (s_q.cnt >= s_q.top) begin
                    if (s_q.top <= ONE) begin
                        wrap    = 1'b1;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt  = s_q.cnt - 1'b1;
                        s_d.down = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                if (s_q.cnt <= ONE) begin
                    wrap     = 1'b1;
                    s_d.cnt  = '0;
                    s_d.down = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end
        load     = ~en | wrap;
        if (load) s_d.top = top_next;
        s_d.pend = en & wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.top <= CW'(TOP_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt        = s_q.cnt;
    assign top_act    = s_q.top;
    assign period_end = s_q.pend;
endmodule

// File: rtl/pwm_decoder.sv
module pwm_decoder
    import pwm_core_pkg::*;
#(
    parameter int CW      = 15,
    parameter int TOP_RST = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  load_mode_e              mode,
    input  logic [CW-1:0]           top_cfg,
    input  logic                    wd_valid,
    input  logic [CW:0]             wd_data,
    output logic                    wd_ready,
    input  logic                    load,
    output logic [NCH-1:0][CW:0]    act,
    output logic [CW-1:0]           top_next
);
    localparam int IW = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0][CW:0] pend;
        logic [NCH-1:0][CW:0] act;
        logic [CW-1:0]        ptop;
        logic [IW-1:0]        idx;
        logic                 full;
        load_mode_e           mode;
    } st_t;

    st_t           s_d, s_q;
    logic          accept;
    logic [IW-1:0] idx_eff;
    logic [IW-1:0] last;

    always_comb begin
        s_d     = s_q;
        s_d.mode = mode;
        idx_eff = (mode != s_q.mode) ? '0 : s_q.idx;
        case (mode)
            LD_COMMON: last = '0;
            LD_PAIRED: last = IW'(1);
            default:   last = IW'(NCH - 1);
        endcase
        accept = wd_valid & ~s_q.full;
        s_d.idx = idx_eff;
        if (accept) begin
            case (mode)
                LD_COMMON: begin
                    for (int i = 0; i < NCH; i++) s_d.pend[i] = wd_data;
                end
                LD_PAIRED: begin
                    for (int i = 0; i < NCH; i++)
                        if (i / 2 == int'(idx_eff)) s_d.pend[i] = wd_data;
                end
                LD_SEPARATE: s_d.pend[idx_eff] = wd_data;
                default: begin
                    if (idx_eff == last) s_d.ptop = wd_data[CW-1:0];
                    else                 s_d.pend[idx_eff] = wd_data;
                end
            endcase
            s_d.idx = (idx_eff == last) ? '0 : idx_eff + 1'b1;
        end
        if (accept && (idx_eff == last)) s_d.full = 1'b1;
        else if (load)                   s_d.full = 1'b0;
        if (load) s_d.act = s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ptop <= CW'(TOP_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign wd_ready = ~s_q.full;
    assign act      = s_q.act;
    assign top_next = (mode == LD_WAVE) ? s_q.ptop : top_cfg;
endmodule

// File: rtl/pwm_outdrv.sv
module pwm_outdrv
    import pwm_core_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic                 en,
    input  logic                 wave,
    input  logic [CW-1:0]        cnt,
    input  logic [NCH-1:0][CW:0] cmp,
    input  logic [NCH-1:0]       off,
    output logic [NCH-1:0]       out
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic lvl;
        assign lvl = (cnt < cmp[g][CW-1:0]) ^ cmp[g][CW];
        if (g == NCH - 1) begin : g_last
            assign out[g] = en & ~off[g] & ~wave & lvl;
        end else begin : g_norm
            assign out[g] = en & ~off[g] & lvl;
        end
    end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_core_pkg::*;
#(
    parameter int CW      = 15,
    parameter int PSW     = 3,
    parameter int TOP_RST = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [PSW-1:0] div_sel,
    input  logic           center_mode,
    input  logic [1:0]     load_mode,
    input  logic [CW-1:0]  top_cfg,
    input  logic [NCH-1:0] chan_off,
    input  logic           wd_valid,
    input  logic [CW:0]    wd_data,
    output logic           wd_ready,
    output logic [NCH-1:0] pwm_out,
    output logic           period_end
);
    logic                 tick_w;
    logic                 load_w;
    logic [CW-1:0]        cnt_w;
    logic [CW-1:0]        top_w;
    logic [CW-1:0]        topn_w;
    logic [NCH-1:0][CW:0] act_w;
    load_mode_e           mode_w;

    assign mode_w = load_mode_e'(load_mode);

    pwm_prescaler #(.PSW(PSW)) u_pre (
        .clk (clk),
        .rst_n (rst_n),
        .en  (enable),
        .sel (div_sel),
        .tick(tick_w)
    );

    pwm_counter #(.CW(CW), .TOP_RST(TOP_RST)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .tick      (tick_w),
        .center    (center_mode),
        .top_next  (topn_w),
        .cnt       (cnt_w),
        .top_act   (top_w),
        .load      (load_w),
        .period_end(period_end)
    );

    pwm_decoder #(.CW(CW), .TOP_RST(TOP_RST)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_w),
        .top_cfg (top_cfg),
        .wd_valid(wd_valid),
        .wd_data (wd_data),
        .wd_ready(wd_ready),
        .load    (load_w),
        .act     (act_w),
        .top_next(topn_w)
    );

    pwm_outdrv #(.CW(CW)) u_out (
        .en  (enable),
        .wave(mode_w == LD_WAVE),
        .cnt (cnt_w),
        .cmp (act_w),
        .off (chan_off),
        .out (pwm_out)
    );
endmodule

// File: rtl/pwm_core_chk.sv
module pwm_core_chk
    import pwm_core_pkg::*;
#(
    parameter int CW = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic [1:0]           load_mode,
    input logic [NCH-1:0]       chan_off,
    input logic                 wd_valid,
    input logic                 wd_ready,
    input logic [NCH-1:0]       pwm_out,
    input logic                 period_end,
    input logic [CW-1:0]        cnt,
    input logic [CW-1:0]        top_act,
    input logic [NCH-1:0][CW:0] cmp_act
);
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (pwm_out == '0 && !period_end));

    a_r11_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_ready) |-> $past(wd_valid));

    a_r11_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_ready) |-> (period_end || $past(!enable)));

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= top_act);

    a_r10_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cmp_act) || !$stable(top_act)) |-> (period_end || $past(!enable)));

    a_r8_ch3_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode == 2'd3) |-> !pwm_out[NCH-1]);

    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & chan_off) == '0);
endmodule

bind pwm_core pwm_core_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load_mode (load_mode),
    .chan_off  (chan_off),
    .wd_valid  (wd_valid),
    .wd_ready  (wd_ready),
    .pwm_out   (pwm_out),
    .period_end(period_end),
    .cnt       (cnt_w),
    .top_act   (top_w),
    .cmp_act   (act_w)
);

// File: tb/pwm_core_tb_top.sv
module pwm_core_tb_top;
    import pwm_core_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 15;
    localparam int PSW = 3;

    logic           clk;
    logic           rst_n;
    logic           enable;
    logic [PSW-1:0] div_sel;
    logic           center_mode;
    logic [1:0]     load_mode;
    logic [CW-1:0]  top_cfg;
    logic [NCH-1:0] chan_off;
    logic           wd_valid;
    logic [CW:0]    wd_data;
    logic           wd_ready;
    logic [NCH-1:0] pwm_out;
    logic           period_end;

    pwm_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .div_sel    (div_sel),
        .center_mode(center_mode),
        .load_mode  (load_mode),
        .top_cfg    (top_cfg),
        .chan_off   (chan_off),
        .wd_valid   (wd_valid),
        .wd_data    (wd_data),
        .wd_ready   (wd_ready),
        .pwm_out    (pwm_out),
        .period_end (period_end)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    typedef struct {
        string tag;
        int    cyc;
        int    hi[NCH];
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   nper   = 0;
    int   mcyc   = 0;
    int   mhi[NCH];
    bit   mlive  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic exp_t mk(input string t, input int c,
                                input int a, input int b, input int d, input int f);
        exp_t e;
        e.tag = t; e.cyc = c;
        e.hi[0] = a; e.hi[1] = b; e.hi[2] = d; e.hi[3] = f;
        return e;
    endfunction

    // Monitor: measures complete periods between strobes, pops and compares.
    always @(negedge clk) begin
        if (!rst_n || !enable) begin
            mlive = 0;
        end else if (period_end) begin
            if (mlive && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(mcyc == e.cyc, e.tag, "period cycles", mcyc, e.cyc);
                for (int i = 0; i < NCH; i++)
                    check(mhi[i] == e.hi[i], e.tag, $sformatf("ch%0d high cycles", i), mhi[i], e.hi[i]);
            end
            mlive = 1;
            mcyc  = 1;
            for (int i = 0; i < NCH; i++) mhi[i] = int'(pwm_out[i]);
            nper++;
        end else begin
            mcyc++;
            for (int i = 0; i < NCH; i++) mhi[i] += int'(pwm_out[i]);
        end
    end

    task automatic send1(input logic [CW:0] w);
        @(negedge clk);
        while (!wd_ready) @(negedge clk);
        wd_valid = 1'b1;
        wd_data  = w;
        @(negedge clk);
        wd_valid = 1'b0;
    endtask

    task automatic expect_n(input exp_t e, input int reps);
        int tgt;
        tgt = nper + 2;
        wait (nper >= tgt);
        for (int k = 0; k < reps; k++) exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; div_sel = '0; center_mode = 1'b0;
        load_mode = 2'd0; top_cfg = 15'd20; chan_off = '0;
        wd_valid = 1'b0; wd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(pwm_out == '0, "R13", "reset outputs", int'(pwm_out), 0);
        check(period_end == 1'b0, "R13", "reset strobe", int'(period_end), 0);
        check(wd_ready == 1'b1, "R13", "reset ready", int'(wd_ready), 1);

        // R5 common word loaded while idle, R2 edge-aligned period
        send1(16'd5);
        enable = 1'b1;
        expect_n(mk("R2 R5", 21, 5, 5, 5, 5), 2);

        // R4 inverted polarity
        send1(16'h8005);
        expect_n(mk("R4", 21, 16, 16, 16, 16), 1);

        // R6 paired words
        load_mode = 2'd1;
        send1(16'd3);
        send1(16'h800C);
        expect_n(mk("R6 R4", 21, 3, 3, 9, 9), 1);

        // R7 separate words, value above top
        load_mode = 2'd2;
        send1(16'd1); send1(16'd7); send1(16'd25); send1(16'd0);
        expect_n(mk("R7 R2", 21, 1, 7, 21, 0), 1);

        // R9 disconnected channel
        chan_off = 4'b0100;
        expect_n(mk("R9", 21, 1, 7, 0, 0), 1);
        chan_off = '0;

        // R3 center-aligned counting
        center_mode = 1'b1;
        expect_n(mk("R3", 40, 1, 13, 40, 0), 1);

        // R1 prescaler divide by 4
        div_sel = 3'd2;
        expect_n(mk("R1 R3", 160, 4, 52, 160, 0), 1);
        div_sel = 3'd0;
        center_mode = 1'b0;

        // R8 waveform mode: fourth word sets top, ch3 low
        load_mode = 2'd3;
        send1(16'd2); send1(16'd4); send1(16'd6); send1(16'd19);
        expect_n(mk("R8", 20, 2, 4, 6, 0), 1);

        // R10 burst mid-period: current period unchanged, next one new
        begin
            int tgt;
            tgt = nper + 1;
            wait (nper >= tgt);
            exp_q.push_back(mk("R10 old", 20, 2, 4, 6, 0));
            exp_q.push_back(mk("R10 new", 30, 8, 1, 3, 0));
            send1(16'd8); send1(16'd1); send1(16'd3); send1(16'd29);
            wait (exp_q.size() == 0);
        end

        // R11 ready low after full group until boundary
        load_mode = 2'd2;
        top_cfg = 15'd60;
        begin
            int tgt;
            tgt = nper + 2;
            wait (nper >= tgt);
            send1(16'd10); send1(16'd20); send1(16'd30); send1(16'd40);
            check(wd_ready == 1'b0, "R11", "ready after group", int'(wd_ready), 0);
            tgt = nper + 1;
            wait (nper >= tgt);
            check(wd_ready == 1'b1, "R11", "ready at boundary", int'(wd_ready), 1);
        end
        expect_n(mk("R7 R11", 61, 10, 20, 30, 40), 1);

        // R12 mode change restarts word position after a stray word
        send1(16'd50);
        load_mode = 2'd0;
        @(negedge clk);
        @(negedge clk);
        load_mode = 2'd2;
        send1(16'd2); send1(16'd3); send1(16'd4); send1(16'd5);
        expect_n(mk("R12", 61, 2, 3, 4, 5), 1);

        // R1 largest divide
        load_mode = 2'd0;
        top_cfg = 15'd3;
        div_sel = 3'd7;
        send1(16'd2);
        expect_n(mk("R1 R5", 512, 256, 256, 256, 256), 1);

        // R13 idle outputs
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pwm_out == '0, "R13", "idle outputs", int'(pwm_out), 0);
        check(period_end == 1'b0, "R13", "idle strobe", int'(period_end), 0);
        finish_run();
    end
endmodule